// File: doc/BRIEF.md
# Frequency Lock Detector with Loss Actions

This block decides whether a phase-locked loop has reached frequency lock by counting two event streams over the same measurement window: ticks of the reference clock and ticks of the loop's feedback clock. Both clocks are given as single-cycle enable pulses in one system clock domain. A window closes on the reference tick that brings the reference count to a programmable terminal count. At that point the feedback count is checked against the same terminal count, with a margin of two counts either way.

A run of in-tolerance windows declares lock. Measurement continues after lock, and one bad window withdraws it. When lock is withdrawn while the operating mode is normal, a sticky loss flag is set. A two-bit selection then decides whether the loss raises a level interrupt, emits a one-cycle reset request, or does nothing. Loss detected in bypass mode leaves the flag untouched. Moving into bypass does not clear a flag that is already set. Software clears the flag by writing one to it, which appears here as a clear strobe.

Top module: `freq_lock_detector`

## Requirements
- R1: A window ends in the cycle where `refTick` is high and the reference count including that tick reaches `termCnt`. The feedback ticks of that window, including a tick in the closing cycle, are in tolerance when they lie within `termCnt` plus or minus 2, both bounds included. Both counts restart at zero after the window ends.
- R2: `locked` rises after the edge that closes the third consecutive in-tolerance window. Any out-of-tolerance window restarts that run.
- R3: While `locked` is high, a single out-of-tolerance window drops `locked` at the edge that closes it. This is a loss-of-lock event.
- R4: Measurement keeps running after lock and after a loss. Three further good windows declare lock again.
- R5: A loss-of-lock event while `modeNormal` is 1 sets `lossFlag` at the same edge. The flag then stays set until it is cleared.
- R6: A loss-of-lock event while `modeNormal` is 0 (bypass) sets no flag and produces no interrupt and no reset request.
- R7: Changing `modeNormal` from 1 to 0 does not clear `lossFlag`.
- R8: `clrFlag` high in a cycle clears `lossFlag` at the next edge. If a flag-setting event occurs in the same cycle, the set wins.
- R9: `actionSel` uses these encodings: 2'b01 selects interrupt, 2'b10 selects reset request, and 2'b00 or 2'b11 select no action. `irqOut` is high exactly while `lossFlag` is 1, `modeNormal` is 1 and `actionSel` is 2'b01. `rstReq` is a one-cycle pulse at the edge of a normal-mode loss event while `actionSel` is 2'b10.
- R10: While `rstN` is low, `locked`, `lossFlag`, `irqOut` and `rstReq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle pulse per reference clock edge |
| fbTick | input | 1 | One-cycle pulse per feedback clock edge |
| termCnt | input | CNT_W | Reference ticks per window, also the expected feedback count |
| modeNormal | input | 1 | 1 = normal mode, 0 = bypass |
| actionSel | input | 2 | Loss action: 01 interrupt, 10 reset request, 00/11 none |
| clrFlag | input | 1 | Write-one-to-clear strobe for the loss flag |
| locked | output | 1 | Frequency lock status |
| lossFlag | output | 1 | Sticky loss-of-lock flag |
| irqOut | output | 1 | Loss-of-lock interrupt level |
| rstReq | output | 1 | One-cycle reset request |

## Verification
A wrong window count or a wrong tolerance bound shows at `locked` at the first window edge that falls on the disputed count. It appears as lock one window too early or too late, or as a missed loss. A corrupted good-window run counter shows only when lock is acquired, up to three windows later. The bench therefore drives feedback counts exactly at and just beyond both tolerance bounds. A wrongly gated flag shows at `lossFlag` and `irqOut` in the same cycle. A wrongly gated reset request shows as a missing or doubled `rstReq` pulse in the cycle after the closing edge. A reference model compared every cycle catches each of these as soon as it reaches a port.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_IRQ   = 2'b01,
    ACT_RESET = 2'b10,
    ACT_IDLE  = 2'b11
  } lossAction_e;

  // strobes passed from the window datapath to the lock control
  typedef struct packed {
    logic winEnd;
    logic inTol;
  } winResult_t;
endpackage

// File: rtl/fld_window_dp.sv
module fld_window_dp
  import fld_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TOL   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             fbTick,
  input  logic [CNT_W-1:0] termCnt,
  output winResult_t       res
);
  localparam int EXT_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] refCnt;
  logic [CNT_W-1:0] fbCnt;
  logic [EXT_W-1:0] refNext;
  logic [EXT_W-1:0] fbFinal;
  logic [EXT_W-1:0] loBound;
  logic [EXT_W-1:0] hiBound;
  logic             winEnd;
  logic             inTol;

  always_comb begin
    refNext = EXT_W'(refCnt) + EXT_W'(refTick);
    fbFinal = EXT_W'(fbCnt) + EXT_W'(fbTick);
    hiBound = EXT_W'(termCnt) + EXT_W'(TOL);
    if (EXT_W'(termCnt) > EXT_W'(TOL)) loBound = EXT_W'(termCnt) - EXT_W'(TOL);
    else loBound = '0;
    winEnd = refTick && (refNext >= EXT_W'(termCnt));
    inTol  = (fbFinal >= loBound) && (fbFinal <= hiBound);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
      fbCnt  <= '0;
    end else if (winEnd) begin
      refCnt <= '0;
      fbCnt  <= '0;
    end else begin
      if (refTick && refCnt != CNT_MAX) refCnt <= refCnt + 1'b1;
      if (fbTick && fbCnt != CNT_MAX) fbCnt <= fbCnt + 1'b1;
    end
  end

  assign res.winEnd = winEnd;
  assign res.inTol  = inTol;

  // R1: a closed window restarts both counts
  a_r1_window_restart: assert property (@(posedge clk) disable iff (!rstN)
    winEnd |=> (refCnt == '0 && fbCnt == '0));
  // R1: without a reference tick the reference count holds
  a_r1_ref_hold: assert property (@(posedge clk) disable iff (!rstN)
    !refTick |=> $stable(refCnt) || refCnt == '0);
endmodule

// File: rtl/fld_lock_ctrl.sv
module fld_lock_ctrl
  import fld_pkg::*;
#(
  parameter int LOCK_WINDOWS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  winResult_t res,
  input  logic       modeNormal,
  input  logic [1:0] actionSel,
  input  logic       clrFlag,
  output logic       locked,
  output logic       lossFlag,
  output logic       irqOut,
  output logic       rstReq
);
  localparam int RUN_W = $clog2(LOCK_WINDOWS + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_WINDOWS);

  logic [RUN_W-1:0] goodRun;
  logic             lossEvent;
  logic             lossNormal;
  lossAction_e      act;

  assign act        = lossAction_e'(actionSel);
  assign lossEvent  = res.winEnd && !res.inTol && locked;
  assign lossNormal = lossEvent && modeNormal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodRun <= '0;
      locked  <= 1'b0;
    end else if (res.winEnd) begin
      if (res.inTol) begin
        if (goodRun < RUN_TOP) goodRun <= goodRun + 1'b1;
        if (goodRun + 1'b1 >= RUN_TOP) locked <= 1'b1;
      end else begin
        goodRun <= '0;
        locked  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lossFlag <= 1'b0;
      rstReq   <= 1'b0;
    end else begin
      if (lossNormal) lossFlag <= 1'b1;
      else if (clrFlag) lossFlag <= 1'b0;
      rstReq <= lossNormal && (act == ACT_RESET);
    end
  end

  assign irqOut = lossFlag && modeNormal && (act == ACT_IRQ);

  // R3: one bad window while locked withdraws lock
  a_r3_loss_drops_lock: assert property (@(posedge clk) disable iff (!rstN)
    (locked && res.winEnd && !res.inTol) |=> !locked);
  // R6: bypass never raises the flag
  a_r6_bypass_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (!modeNormal && !lossFlag) |=> !lossFlag);
  // R7: flag stays set until a clear strobe
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lossFlag && !clrFlag) |=> lossFlag);
  // R9: reset request lasts a single cycle
  a_r9_rst_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  // R9: reset request only follows a flag-setting event
  a_r9_rst_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> lossFlag);
endmodule

// File: rtl/freq_lock_detector.sv
module freq_lock_detector
  import fld_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int TOL          = 2,
  parameter int LOCK_WINDOWS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             fbTick,
  input  logic [CNT_W-1:0] termCnt,
  input  logic             modeNormal,
  input  logic [1:0]       actionSel,
  input  logic             clrFlag,
  output logic             locked,
  output logic             lossFlag,
  output logic             irqOut,
  output logic             rstReq
);
  winResult_t winRes;

  fld_window_dp #(.CNT_W(CNT_W), .TOL(TOL)) uDp (
    .clk(clk), .rstN(rstN), .refTick(refTick), .fbTick(fbTick),
    .termCnt(termCnt), .res(winRes)
  );

  fld_lock_ctrl #(.LOCK_WINDOWS(LOCK_WINDOWS)) uCtrl (
    .clk(clk), .rstN(rstN), .res(winRes), .modeNormal(modeNormal),
    .actionSel(actionSel), .clrFlag(clrFlag), .locked(locked),
    .lossFlag(lossFlag), .irqOut(irqOut), .rstReq(rstReq)
  );

  // R10: nothing is reported while held in reset
  always_comb begin
    if (!rstN) a_r10_reset_quiet: assert (!locked && !lossFlag && !rstReq);
  end
endmodule

// File: tb/tb_freq_lock_detector.sv
module tb_freq_lock_detector;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0, fbTick = 1'b0, clrFlag = 1'b0;
  logic [7:0] termCnt = 8'd10;
  logic       modeNormal = 1'b1;
  logic [1:0] actionSel = 2'b01;
  logic       locked, lossFlag, irqOut, rstReq;

  int nCmp = 0, nBad = 0, cycles = 0;
  // reference model state
  int mRef = 0, mFb = 0, mRun = 0;
  bit mLocked = 0, mFlag = 0, mRst = 0;

  always #10 clk = ~clk;

  freq_lock_detector dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .fbTick(fbTick),
    .termCnt(termCnt), .modeNormal(modeNormal), .actionSel(actionSel),
    .clrFlag(clrFlag), .locked(locked), .lossFlag(lossFlag),
    .irqOut(irqOut), .rstReq(rstReq)
  );

  always @(posedge clk) begin
    bit endW, good, loss;
    cycles++;
    if (!rstN) begin
      mRef = 0; mFb = 0; mRun = 0; mLocked = 0; mFlag = 0; mRst = 0;
    end else begin
      endW = refTick && (mRef + 1 >= int'(termCnt));
      good = (mFb + int'(fbTick) >= int'(termCnt) - 2) && (mFb + int'(fbTick) <= int'(termCnt) + 2);
      loss = endW && !good && mLocked;
      mRst = loss && modeNormal && actionSel == 2'b10;
      if (loss && modeNormal) mFlag = 1;
      else if (clrFlag) mFlag = 0;
      if (endW) begin
        if (good) begin
          mRun++;
          if (mRun >= 3) mLocked = 1;
        end else begin
          mRun = 0; mLocked = 0;
        end
        mRef = 0; mFb = 0;
      end else begin
        mRef += int'(refTick);
        mFb  += int'(fbTick);
      end
    end
  end

  task automatic cmp(input string tag, input logic act, input logic exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, cycles, act, exp);
    end
  endtask

  task automatic checkAll();
    cmp("R1 R2 R3 R4 locked", locked, mLocked);
    cmp("R5 R6 R7 R8 lossFlag", lossFlag, mFlag);
    cmp("R6 R9 irqOut", irqOut, mFlag && modeNormal && actionSel == 2'b01);
    cmp("R6 R9 rstReq", rstReq, mRst);
  endtask

  task automatic step(input logic r, input logic f, input logic c);
    @(negedge clk);
    checkAll();
    refTick = r; fbTick = f; clrFlag = c;
  endtask

  // one window of 2*termCnt cycles, reference tick on odd cycles,
  // nFb feedback ticks at the start, optional clear on the closing cycle
  task automatic runWindow(input int nFb, input logic clrLast = 1'b0);
    int len = 2 * int'(termCnt);
    for (int i = 0; i < len; i++)
      step(i[0], i < nFb, clrLast && (i == len - 1));
  endtask

  task automatic idle(input logic c);
    step(1'b0, 1'b0, c);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      cmp("R10 locked", locked, 1'b0);
      cmp("R10 lossFlag", lossFlag, 1'b0);
      cmp("R10 irqOut", irqOut, 1'b0);
      cmp("R10 rstReq", rstReq, 1'b0);
    end
    rstN = 1'b1;
    // R2: lock after three good windows, with a bad window restarting the run
    runWindow(10); runWindow(10); runWindow(14); runWindow(10);
    runWindow(10); runWindow(10);
    // R1: both tolerance bounds stay locked
    runWindow(12); runWindow(8);
    // R3 R5 R9: just outside the upper bound, interrupt selected
    runWindow(13);
    idle(1'b0);
    // R4: relock
    runWindow(9); runWindow(11); runWindow(10);
    // R8: clear removes flag and interrupt
    idle(1'b1); idle(1'b0);
    // R9: reset request on loss below the lower bound
    actionSel = 2'b10;
    runWindow(7); runWindow(10); runWindow(10); runWindow(10); runWindow(10);
    idle(1'b0); idle(1'b1);
    // R9: encoding 11 takes no action beyond the flag
    actionSel = 2'b11;
    runWindow(10); runWindow(10); runWindow(10); runWindow(3);
    // R7: flag survives the move to bypass
    actionSel = 2'b01;
    idle(1'b0);
    modeNormal = 1'b0;
    idle(1'b0); idle(1'b0);
    modeNormal = 1'b1;
    idle(1'b0);
    modeNormal = 1'b0;
    idle(1'b1); idle(1'b0);
    // R6: loss in bypass sets nothing
    actionSel = 2'b10;
    runWindow(10); runWindow(10); runWindow(10); runWindow(15);
    idle(1'b0);
    // R8: set wins over a clear in the same cycle
    modeNormal = 1'b1;
    actionSel = 2'b01;
    runWindow(10); runWindow(10); runWindow(10); runWindow(0, 1'b1);
    idle(1'b0); idle(1'b1); idle(1'b0);
    // R1: different terminal count
    termCnt = 8'd4;
    runWindow(4); runWindow(6); runWindow(2); runWindow(1);
    idle(1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    wait (cycles > 200000);
    nBad++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule